// File: doc/BRIEF.md
# Lockable Patch Control Register File

This block is the control store of a memory patching unit. It holds twenty 16-bit registers on a word-addressed bus with separate byte write strobes: a mode word, a sticky "has been written" status bit, and six slots, each with a patch address (address bits 23 to 1) and 16 bits of replacement data. The mode word decides which source answers reads in the ROM window: the boot ROM, this register file, or the cartridge ROM. It also carries one enable bit per patch code and a lock bit.

Once software has loaded the patch slots, it sets the lock bit so that nothing can alter the registers until the next reset. There are two resets. A cold reset clears everything. A warm reset clears only the mode, lock and enable bits, and the patch slots and the status bit keep their values. The decode of the word index is partial: the twelve words above the slot range read back as copies of the last two slots, and writes to them are dropped.

Registers are big-endian: the even byte of a word is its upper half, bits 15:8, and it is written by `wr_hi`. The odd byte, bits 7:0, is written by `wr_lo`. A read issued with `rd_en` returns its word on `rdata` one clock later, marked by `rd_valid`.

Top module: `patch_ctl_regs`

## Requirements
- R1: Word 0 is the mode word. Bits 10:9 hold the source mode, bit 8 holds the lock and bits 5:0 hold the enables of codes 6..1 (bit 0 is code 1, on `code_en[0]`). All other bits read as 0.
- R2: Exactly one source select is high at any time. Mode 00 selects `sel_boot`, mode 01 selects `sel_regs`, and a mode with bit 10 set selects `sel_cart` whatever bit 9 holds.
- R3: While the lock bit is 1, a write to any word changes no register.
- R4: A warm reset (`warm_rst_n` low at a clock edge) clears the lock bit, after which writes are accepted again.
- R5: Bit 0 of word 1 is set by any accepted write to word 1, whatever the data. Only a cold reset clears it, and it survives warm resets. Bits 15:1 of word 1 read as 0.
- R6: Slot n (1..6) occupies words 2+3(n-1), 3+3(n-1) and 4+3(n-1): address bits 15..1, then address bits 23..16, then the data. `slot_addr[23(n-1) +: 23]` presents address bits 23:1 and `slot_data[16(n-1) +: 16]` presents the data.
- R7: Words 20..31 read as slots 5, 6, 5, 6 in groups of three words, in the same field order. Writes to them change no register.
- R8: `wr_hi` updates only bits 15:8 of the addressed word and `wr_lo` updates only bits 7:0.
- R9: A warm reset clears the mode word and leaves the slots and the status bit unchanged. A cold reset (`cold_rst_n` low) clears every register.
- R10: A read with `rd_en` high at a clock edge presents that word on `rdata` with `rd_valid` high after that edge. Without `rd_en`, `rdata` holds its value.
- R11: The address low word reads bit 0 as 0. The address high word reads bits 15:8 as 0 and keeps only the lower byte lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Synchronous cold reset, active low, clears all state |
| warm_rst_n | input | 1 | Synchronous warm reset, active low, clears the mode word |
| word_addr | input | 5 | Word index (byte offset / 2) for reads and writes |
| wr_hi | input | 1 | Write strobe for bits 15:8 (even byte) |
| wr_lo | input | 1 | Write strobe for bits 7:0 (odd byte) |
| wdata | input | 16 | Write data |
| rd_en | input | 1 | Read request for `word_addr` |
| rdata | output | 16 | Read data, registered |
| rd_valid | output | 1 | `rdata` holds the word requested at the previous edge |
| sel_boot | output | 1 | Boot ROM answers reads in the ROM window |
| sel_regs | output | 1 | This register file answers reads in the ROM window |
| sel_cart | output | 1 | Cartridge ROM answers reads in the ROM window |
| lock | output | 1 | Lock bit |
| code_en | output | 6 | Per-code enables, bit 0 is code 1 |
| slot_addr | output | 138 | Six 23-bit patch addresses (bits 23:1), slot 1 lowest |
| slot_data | output | 96 | Six 16-bit patch data words, slot 1 lowest |

## Verification
A write takes effect at the clock edge that samples its strobe. The bench therefore checks the select, lock, enable and slot outputs at the falling edge after that edge, and any read issued from that point on sees the new value. Read data is due exactly one edge after `rd_en`: the driver queues the expected word when it raises `rd_en`, and the monitor pops the queue only on a falling edge where `rd_valid` is high, so a late or early word shows up as a mismatch or as a leftover entry. Resets are held across one edge and are checked at the following falling edge in the same way.

// File: rtl/pcr_pkg.sv
`timescale 1ns/1ps
package pcr_pkg;
  localparam int NSLOT       = 6;
  localparam int WPS         = 3;                     // words per slot
  localparam int DATA_W      = 16;
  localparam int PADDR_W     = 23;                    // address bits 23:1
  localparam int PLO_W       = 15;                    // bits 15:1
  localparam int PHI_W       = PADDR_W - PLO_W;       // bits 23:16
  localparam int AW          = 5;
  localparam int SLOT_BASE   = 2;
  localparam int MIRROR_BASE = SLOT_BASE + WPS * NSLOT;
  localparam int SLOT_IW     = $clog2(NSLOT);
  localparam int MODE_LSB    = 9;
  localparam int LOCK_BIT    = 8;

  typedef enum logic [1:0] {RK_MODE, RK_STAT, RK_SLOT, RK_NONE} reg_kind_e;

  typedef struct packed {
    reg_kind_e          kind;
    logic [SLOT_IW-1:0] slot;
    logic [1:0]         field;   // 0 addr low, 1 addr high, 2 data
    logic               wr_ok;
  } reg_dec_t;

  function automatic reg_dec_t decode_word(logic [AW-1:0] w);
    reg_dec_t d;
    int iw;
    int rel;
    d.kind  = RK_NONE;
    d.slot  = '0;
    d.field = '0;
    d.wr_ok = 1'b0;
    iw = int'(w);
    if (iw == 0) begin
      d.kind  = RK_MODE;
      d.wr_ok = 1'b1;
    end else if (iw == 1) begin
      d.kind  = RK_STAT;
      d.wr_ok = 1'b1;
    end else if (iw < MIRROR_BASE) begin
      rel     = iw - SLOT_BASE;
      d.kind  = RK_SLOT;
      d.slot  = SLOT_IW'(rel / WPS);
      d.field = 2'(rel % WPS);
      d.wr_ok = 1'b1;
    end else begin
      rel     = iw - MIRROR_BASE;
      d.kind  = RK_SLOT;
      d.slot  = SLOT_IW'(NSLOT - 2 + ((rel / WPS) % 2));
      d.field = 2'(rel % WPS);
    end
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] addr_lo_word(logic [PADDR_W-1:0] a);
    return {a[PLO_W-1:0], 1'b0};
  endfunction

  function automatic logic [DATA_W-1:0] addr_hi_word(logic [PADDR_W-1:0] a);
    return {{(DATA_W-PHI_W){1'b0}}, a[PADDR_W-1:PLO_W]};
  endfunction

  function automatic logic [DATA_W-1:0] mode_word(logic [1:0] m, logic lk,
                                                  logic [NSLOT-1:0] en);
    logic [DATA_W-1:0] r;
    r = '0;
    r[MODE_LSB+1:MODE_LSB] = m;
    r[LOCK_BIT]            = lk;
    r[NSLOT-1:0]           = en;
    return r;
  endfunction
endpackage

// File: rtl/pcr_ctrl.sv
`timescale 1ns/1ps
module pcr_ctrl
  import pcr_pkg::*;
(
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             warm_rst_n,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic             wr_stat,
  input  logic [2:0]       wd_ctl,
  input  logic [NSLOT-1:0] wd_en,
  output logic [1:0]       mode,
  output logic             lock,
  output logic [NSLOT-1:0] code_en,
  output logic             status
);
  logic [1:0]       mode_q;
  logic             lock_q;
  logic [NSLOT-1:0] en_q;
  logic             stat_q;

  always_ff @(posedge clk) begin
    if (!cold_rst_n || !warm_rst_n) begin
      mode_q <= '0;
      lock_q <= 1'b0;
      en_q   <= '0;
    end else begin
      if (wr_hi) {mode_q, lock_q} <= wd_ctl;
      if (wr_lo) en_q <= wd_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!cold_rst_n)  stat_q <= 1'b0;
    else if (wr_stat) stat_q <= 1'b1;
  end

  assign mode    = mode_q;
  assign lock    = lock_q;
  assign code_en = en_q;
  assign status  = stat_q;

  // R4 / R9: a warm reset leaves the mode word cleared
  p_warm_clear_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst_n |=> (!lock_q && mode_q == 2'b00 && en_q == '0));

  // R5: the status bit only falls through a cold reset
  p_status_keep_r5: assert property (@(posedge clk) disable iff (!cold_rst_n)
    stat_q |=> stat_q);

  // R5: an accepted status write sets the bit
  p_status_set_r5: assert property (@(posedge clk) disable iff (!cold_rst_n)
    wr_stat |=> stat_q);
endmodule

// File: rtl/pcr_src_sel.sv
`timescale 1ns/1ps
module pcr_src_sel (
  input  logic       clk,
  input  logic       cold_rst_n,
  input  logic [1:0] mode,
  output logic       sel_boot,
  output logic       sel_regs,
  output logic       sel_cart
);
  always_comb begin
    sel_boot = 1'b0;
    sel_regs = 1'b0;
    sel_cart = 1'b0;
    unique case (mode)
      2'b00:   sel_boot = 1'b1;
      2'b01:   sel_regs = 1'b1;
      default: sel_cart = 1'b1;
    endcase
  end

  // R2: one source at a time
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $countones({sel_boot, sel_regs, sel_cart}) == 1);
endmodule

// File: rtl/pcr_slot.sv
`timescale 1ns/1ps
module pcr_slot
  import pcr_pkg::*;
(
  input  logic               clk,
  input  logic               cold_rst_n,
  input  logic               wr_hi,
  input  logic               wr_lo,
  input  logic [2:0]         field_sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [PADDR_W-1:0] paddr,
  output logic [DATA_W-1:0]  pdata
);
  logic [PADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]  data_q;

  always_ff @(posedge clk) begin
    if (!cold_rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (field_sel[0]) begin
        if (wr_hi) addr_q[PLO_W-1:7] <= wdata[15:8];
        if (wr_lo) addr_q[6:0]       <= wdata[7:1];
      end
      if (field_sel[1] && wr_lo) addr_q[PADDR_W-1:PLO_W] <= wdata[PHI_W-1:0];
      if (field_sel[2]) begin
        if (wr_hi) data_q[15:8] <= wdata[15:8];
        if (wr_lo) data_q[7:0]  <= wdata[7:0];
      end
    end
  end

  assign paddr = addr_q;
  assign pdata = data_q;

  // R8: an upper-lane write leaves the lower byte of the data
  p_lane_hi_only_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (field_sel[2] && wr_hi && !wr_lo) |=> $stable(data_q[7:0]));

  // R8: a lower-lane write leaves the upper byte of the data
  p_lane_lo_only_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (field_sel[2] && wr_lo && !wr_hi) |=> $stable(data_q[15:8]));
endmodule

// File: rtl/patch_ctl_regs.sv
`timescale 1ns/1ps
module patch_ctl_regs
  import pcr_pkg::*;
(
  input  logic                       clk,
  input  logic                       cold_rst_n,
  input  logic                       warm_rst_n,
  input  logic [AW-1:0]              word_addr,
  input  logic                       wr_hi,
  input  logic                       wr_lo,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rd_valid,
  output logic                       sel_boot,
  output logic                       sel_regs,
  output logic                       sel_cart,
  output logic                       lock,
  output logic [NSLOT-1:0]           code_en,
  output logic [NSLOT*PADDR_W-1:0]   slot_addr,
  output logic [NSLOT*DATA_W-1:0]    slot_data
);
  reg_dec_t           dec;
  logic               any_wr;
  logic               wr_gate;
  logic               slot_wr;
  logic               wr_to_mirror;
  logic [1:0]         mode;
  logic               status;
  logic [PADDR_W-1:0] paddr_a [NSLOT];
  logic [DATA_W-1:0]  pdata_a [NSLOT];
  logic [DATA_W-1:0]  rd_word;

  assign dec          = decode_word(word_addr);
  assign any_wr       = wr_hi | wr_lo;
  assign wr_gate      = any_wr && !lock && dec.wr_ok;
  assign slot_wr      = wr_gate && dec.kind == RK_SLOT;
  assign wr_to_mirror = any_wr && dec.kind == RK_SLOT && !dec.wr_ok;

  pcr_ctrl u_ctrl (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .wr_hi      (wr_gate && dec.kind == RK_MODE && wr_hi),
    .wr_lo      (wr_gate && dec.kind == RK_MODE && wr_lo),
    .wr_stat    (wr_gate && dec.kind == RK_STAT),
    .wd_ctl     (wdata[MODE_LSB+1:LOCK_BIT]),
    .wd_en      (wdata[NSLOT-1:0]),
    .mode       (mode),
    .lock       (lock),
    .code_en    (code_en),
    .status     (status)
  );

  pcr_src_sel u_sel (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .mode       (mode),
    .sel_boot   (sel_boot),
    .sel_regs   (sel_regs),
    .sel_cart   (sel_cart)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [2:0] fsel;
    assign fsel = (slot_wr && dec.slot == SLOT_IW'(g)) ? (3'b001 << dec.field) : 3'b000;

    pcr_slot u_slot (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .wr_hi      (wr_hi),
      .wr_lo      (wr_lo),
      .field_sel  (fsel),
      .wdata      (wdata),
      .paddr      (paddr_a[g]),
      .pdata      (pdata_a[g])
    );

    assign slot_addr[g*PADDR_W +: PADDR_W] = paddr_a[g];
    assign slot_data[g*DATA_W +: DATA_W]   = pdata_a[g];
  end

  always_comb begin
    rd_word = '0;
    case (dec.kind)
      RK_MODE: rd_word = mode_word(mode, lock, code_en);
      RK_STAT: rd_word = {{(DATA_W-1){1'b0}}, status};
      RK_SLOT: begin
        case (dec.field)
          2'd0:    rd_word = addr_lo_word(paddr_a[dec.slot]);
          2'd1:    rd_word = addr_hi_word(paddr_a[dec.slot]);
          default: rd_word = pdata_a[dec.slot];
        endcase
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!cold_rst_n || !warm_rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  // R3: while locked, no register moves
  p_lock_freeze_r3: assert property (@(posedge clk)
    disable iff (!cold_rst_n || !warm_rst_n)
    lock |=> ($stable(slot_addr) && $stable(slot_data) && $stable(code_en)
              && $stable(mode) && $stable(status)));

  // R7: a write aimed at a mirror word changes no slot
  p_mirror_ro_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
    wr_to_mirror |=> ($stable(slot_addr) && $stable(slot_data)));

  // R10: read data holds when no read is requested
  p_rd_hold_r10: assert property (@(posedge clk)
    disable iff (!cold_rst_n || !warm_rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_patch_ctl_regs.sv
`timescale 1ns/1ps
module test_patch_ctl_regs;
  logic         clk = 1'b0;
  logic         cold_rst_n = 1'b0;
  logic         warm_rst_n = 1'b0;
  logic [4:0]   word_addr = '0;
  logic         wr_hi = 1'b0;
  logic         wr_lo = 1'b0;
  logic [15:0]  wdata = '0;
  logic         rd_en = 1'b0;
  logic [15:0]  rdata;
  logic         rd_valid;
  logic         sel_boot, sel_regs, sel_cart, lock;
  logic [5:0]   code_en;
  logic [137:0] slot_addr;
  logic [95:0]  slot_data;

  always #2 clk = ~clk;  // 250 MHz

  patch_ctl_regs i_patch_ctl_regs (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .word_addr(word_addr), .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .rd_valid(rd_valid),
    .sel_boot(sel_boot), .sel_regs(sel_regs), .sel_cart(sel_cart),
    .lock(lock), .code_en(code_en), .slot_addr(slot_addr), .slot_data(slot_data)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model
  logic [15:0] m_mode;       // readback image of word 0
  logic        m_stat;
  logic [22:0] m_addr [6];   // address bits 23:1
  logic [15:0] m_data [6];

  logic [15:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(int w);
    int s, f;
    if (w == 0) return m_mode;
    if (w == 1) return {15'd0, m_stat};
    if (w < 20) begin
      s = (w - 2) / 3; f = (w - 2) % 3;
    end else begin
      f = (w - 20) % 3;
      s = (((w - 20) % 6) < 3) ? 4 : 5;
    end
    if (f == 0) return {m_addr[s][14:0], 1'b0};
    if (f == 1) return {8'h00, m_addr[s][22:15]};
    return m_data[s];
  endfunction

  function automatic void m_write(int w, logic [15:0] d, bit hi, bit lo);
    int s, f;
    if (m_mode[8]) return;
    if (w == 0) begin
      if (hi) m_mode[10:8] = d[10:8];
      if (lo) m_mode[5:0]  = d[5:0];
    end else if (w == 1) begin
      if (hi || lo) m_stat = 1'b1;
    end else if (w < 20) begin
      s = (w - 2) / 3; f = (w - 2) % 3;
      if (f == 0) begin
        if (hi) m_addr[s][14:7] = d[15:8];
        if (lo) m_addr[s][6:0]  = d[7:1];
      end else if (f == 1) begin
        if (lo) m_addr[s][22:15] = d[7:0];
      end else begin
        if (hi) m_data[s][15:8] = d[15:8];
        if (lo) m_data[s][7:0]  = d[7:0];
      end
    end
  endfunction

  function automatic void m_cold();
    m_mode = '0; m_stat = 1'b0;
    for (int i = 0; i < 6; i++) begin m_addr[i] = '0; m_data[i] = '0; end
  endfunction

  task automatic wr(int w, logic [15:0] d, bit hi, bit lo);
    @(negedge clk);
    word_addr = 5'(w); wdata = d; wr_hi = hi; wr_lo = lo;
    m_write(w, d, hi, lo);
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  task automatic rd(int w, string tag);
    @(negedge clk);
    word_addr = 5'(w); rd_en = 1'b1;
    exp_q.push_back(m_read(w));
    tag_q.push_back($sformatf("%s word %0d", tag, w));
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic warm_reset();
    @(negedge clk); warm_rst_n = 1'b0;
    @(negedge clk); warm_rst_n = 1'b1;
    m_mode = '0;
  endtask

  task automatic cold_reset();
    @(negedge clk); cold_rst_n = 1'b0;
    @(negedge clk); cold_rst_n = 1'b1;
    m_cold();
  endtask

  task automatic chk_slots(string tag);
    for (int s = 0; s < 6; s++) begin
      chk(tag, 32'(slot_addr[s*23 +: 23]), 32'(m_addr[s]));
      chk(tag, 32'(slot_data[s*16 +: 16]), 32'(m_data[s]));
    end
  endtask

  // monitor: pops one expected word per valid read
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected rd_valid actual=%0h expected=none", rdata);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, 32'(rdata), 32'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_cold();
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1; warm_rst_n = 1'b1;

    // reset state
    rd(0, "R1 reset mode"); rd(1, "R5 reset status");
    chk("R2 reset boot select", 32'({sel_boot, sel_regs, sel_cart}), 32'b100);
    chk("R3 reset lock", 32'(lock), 0);

    // R2 mode decoding
    wr(0, 16'h0200, 1, 1);
    chk("R2 mode 01 regs", 32'({sel_boot, sel_regs, sel_cart}), 32'b010);
    rd(0, "R1 mode 0200");
    wr(0, 16'h0400, 1, 1);
    chk("R2 mode 10 cart", 32'({sel_boot, sel_regs, sel_cart}), 32'b001);
    wr(0, 16'h0600, 1, 1);
    chk("R2 mode 11 cart", 32'({sel_boot, sel_regs, sel_cart}), 32'b001);
    // R1 junk bits ignored, enables
    wr(0, 16'hF8FF, 1, 1);
    rd(0, "R1 junk bits");
    chk("R1 code_en", 32'(code_en), 32'h3F);
    chk("R2 back to boot", 32'({sel_boot, sel_regs, sel_cart}), 32'b100);

    // R6 slot layout
    for (int s = 0; s < 6; s++) begin
      wr(2 + 3*s, 16'h1356 + 16'(s) * 16'h1112, 1, 1);
      wr(3 + 3*s, 16'h0040 + 16'(s), 1, 1);
      wr(4 + 3*s, 16'hC0DE ^ (16'(s) << 4), 1, 1);
    end
    for (int w = 2; w < 20; w++) rd(w, "R6 slot layout");
    chk_slots("R6 slot ports");

    // R11 unused address bits
    wr(2, 16'hFFFF, 1, 1); wr(3, 16'hFFFF, 1, 1);
    rd(2, "R11 addr low bit0"); rd(3, "R11 addr high upper");
    chk("R11 slot1 addr port", 32'(slot_addr[22:0]), 32'h7FFFFF);

    // R8 byte lanes
    wr(4, 16'h1234, 1, 1);
    wr(4, 16'hAB00, 1, 0);
    rd(4, "R8 hi lane");
    wr(4, 16'h99CD, 0, 1);
    rd(4, "R8 lo lane");
    chk("R8 data port", 32'(slot_data[15:0]), 32'hABCD);

    // R7 mirrors
    for (int w = 20; w < 32; w++) rd(w, "R7 mirror read");
    wr(20, 16'hDEAD, 1, 1); wr(31, 16'hBEEF, 1, 1); wr(26, 16'h5A5A, 1, 1);
    rd(14, "R7 slot5 after mirror write"); rd(19, "R7 slot6 after mirror write");
    chk_slots("R7 ports after mirror write");

    // R5 status
    wr(1, 16'h0000, 0, 1);
    rd(1, "R5 status set");

    // R9 warm reset keeps slots and status
    warm_reset();
    rd(0, "R9 warm mode"); rd(1, "R5 status after warm"); rd(4, "R9 slot after warm");
    chk("R9 warm boot select", 32'(sel_boot), 1);
    chk_slots("R9 ports after warm");

    // R3 lock
    wr(0, 16'h073F, 1, 1);
    chk("R3 lock set", 32'(lock), 1);
    wr(0, 16'h0000, 1, 1);
    wr(4, 16'h5555, 1, 1);
    wr(7, 16'h1111, 0, 1);
    rd(0, "R3 mode locked"); rd(4, "R3 slot locked"); rd(7, "R3 slot2 locked");
    chk("R3 cart still", 32'(sel_cart), 1);
    chk("R3 code_en held", 32'(code_en), 32'h3F);
    chk_slots("R3 ports locked");

    // R4 warm reset releases lock
    warm_reset();
    chk("R4 lock cleared", 32'(lock), 0);
    wr(4, 16'h5555, 1, 1);
    rd(4, "R4 write after unlock"); rd(0, "R4 mode after warm");

    // R9 cold reset clears everything
    cold_reset();
    rd(1, "R9 status cold"); rd(4, "R9 data cold"); rd(2, "R9 addr cold");
    chk_slots("R9 ports cold");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule